// File: doc/BRIEF.md
# Single-Precision Result Packer

This block takes a floating-point value held in a wide unpacked working form and turns it into a 32-bit IEEE 754 single-precision word. It sits at the end of an arithmetic datapath. The datapath hands over five things:

- the class of the value (zero, number, infinity or NaN);
- the sign;
- a two's-complement unbiased exponent;
- a mantissa with an explicit leading one in its top bit;
- a sticky bit that stands for any nonzero bits lost earlier.

The caller also picks one of four rounding directions.

For ordinary numbers the block chooses between the normal path and the subnormal path. It aligns the mantissa to the 24 significant bits of the target format and rounds it. It then handles two carries: a carry that doubles the significand and a carry that lifts a subnormal into the normal range. When the result is too large, the rounding direction picks between infinity and the largest finite value. Four status flags come with the word: inexact, underflow, overflow and invalid-operation. The result and its flags are registered, so they appear one clock after the input is marked valid.

Top module: `fp32_result_packer`

## Requirements
- R1: While `rst` is high at a rising edge, the next cycle shows `out_valid`, `out_word` and all four flags at 0.
- R2: `out_valid` is `in_valid` delayed by one clock. In a cycle with `in_valid` low, the output word and flags keep their previous values.
- R3: Class code 0 (zero) gives a word holding only the sign in bit 31, with all flags clear.
- R4: Class code 2 (infinity) gives the sign, exponent field 255 and fraction 0, with all flags clear.
- R5: Class code 3 (NaN) gives the sign, exponent field 255 and, as fraction, the 23 mantissa bits just below the leading one (bits MANT_W-2 down to MANT_W-24), with all flags clear.
- R6: Class code 1 (number) with biased exponent (unbiased + 127) of 1 or more keeps the top 24 mantissa bits and rounds by `in_rmode`. The encodings are: 0 nearest with ties to even, 1 toward zero, 2 toward minus infinity, 3 toward plus infinity. The discarded bits and `in_sticky` decide the rounding. Inexact is set exactly when any of them is nonzero.
- R7: If normal-path rounding carries the significand to 2.0, the exponent field is one higher and the fraction is 0.
- R8: A number with biased exponent of 0 or less always sets underflow. It is shifted right by one extra place for each unit the biased exponent lies below 1, rounded by the same rules, and packed with exponent field 0.
- R9: If subnormal rounding carries into the implicit-one position, the word is the smallest normal: exponent field 1, fraction 0.
- R10: A final biased exponent of 255 or more sets overflow, inexact and invalid-operation together.
- R11: On overflow the word is infinity in the following cases: mode 0; mode 3 with a positive sign; mode 2 with a negative sign. Otherwise it is the largest finite value of that sign: exponent field 254, fraction all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input value present this cycle |
| in_class | input | 2 | 0 zero, 1 number, 2 infinity, 3 NaN |
| in_sign | input | 1 | Sign of the value |
| in_exp | input | EXP_W | Unbiased exponent, two's complement |
| in_mant | input | MANT_W | Mantissa, leading one in the top bit |
| in_sticky | input | 1 | OR of bits lost before this block |
| in_rmode | input | 2 | Rounding direction |
| out_valid | output | 1 | Result present |
| out_word | output | 32 | Packed single-precision word |
| out_inexact | output | 1 | Rounding discarded nonzero bits |
| out_underflow | output | 1 | Subnormal path taken |
| out_overflow | output | 1 | Exponent out of range |
| out_invalid | output | 1 | Raised with overflow |

## Verification
The cases that are hardest to reach from the ports are the two rounding carries. One is the largest subnormal becoming the smallest normal. The other is a value one half unit below a power of two, which rounds up into the next binade or past the top of the range. Each needs an exact mantissa together with an exponent at the path boundary. The stimulus builds these values directly: all-ones mantissas at biased exponents 0 and 254, and a mantissa with only the guard position set beyond 24 ones. Each is applied under all four rounding directions and both signs. A long run of pseudo-random vectors is then compared against a behavioural model that rounds by integer remainder comparison, not by guard bits.

// File: rtl/fp32pk_pkg.sv
`timescale 1ns/1ps
package fp32pk_pkg;

    localparam int KEEP_W      = 24;
    localparam int SP_FRAC_W   = 23;
    localparam int SP_EXP_W    = 8;
    localparam int SP_BIAS     = 127;
    localparam int SP_EXP_TOP  = 255;

    typedef enum logic [1:0] {
        CLS_ZERO = 2'd0,
        CLS_NUM  = 2'd1,
        CLS_INF  = 2'd2,
        CLS_NAN  = 2'd3
    } fp_class_e;

    typedef enum logic [1:0] {
        RND_NEAR_EVEN = 2'd0,
        RND_TO_ZERO   = 2'd1,
        RND_DOWN      = 2'd2,
        RND_UP        = 2'd3
    } rnd_mode_e;

    typedef struct packed {
        logic [KEEP_W-1:0] kept;
        logic              guard;
        logic              rest;
    } align_t;

    typedef struct packed {
        logic                 sign;
        logic [SP_EXP_W-1:0]  expo;
        logic [SP_FRAC_W-1:0] frac;
    } sp_word_t;

    typedef struct packed {
        logic inexact;
        logic underflow;
        logic overflow;
        logic invalid;
    } sp_flags_t;

    function automatic logic round_up(rnd_mode_e mode, logic sign, logic lsb,
                                      logic guard, logic rest);
        logic lossy;
        lossy = guard | rest;
        unique case (mode)
            RND_NEAR_EVEN: return guard & (rest | lsb);
            RND_TO_ZERO:   return 1'b0;
            RND_DOWN:      return sign & lossy;
            RND_UP:        return ~sign & lossy;
            default:       return 1'b0;
        endcase
    endfunction

    function automatic logic overflow_to_inf(rnd_mode_e mode, logic sign);
        unique case (mode)
            RND_NEAR_EVEN: return 1'b1;
            RND_TO_ZERO:   return 1'b0;
            RND_DOWN:      return sign;
            RND_UP:        return ~sign;
            default:       return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/fp32pk_align.sv
`timescale 1ns/1ps
module fp32pk_align
    import fp32pk_pkg::*;
#(
    parameter int EXP_W  = 10,
    parameter int MANT_W = 32
) (
    input  logic [EXP_W-1:0]        exp_in,
    input  logic [MANT_W-1:0]       mant_in,
    input  logic                    sticky_in,
    output align_t                  al,
    output logic                    tiny,
    output logic signed [EXP_W+1:0] biased
);
    localparam int BW      = EXP_W + 2;
    localparam int EXT_W   = 2 * MANT_W;
    localparam int SH_W    = $clog2(EXT_W);
    localparam int NORM_SH = MANT_W - KEEP_W;

    logic signed [BW-1:0] exp_sx;
    logic [EXT_W-1:0]     ext_w;
    logic [EXT_W-1:0]     shifted;
    logic [SH_W-1:0]      shamt;
    int                   sh_req;

    assign exp_sx = {{2{exp_in[EXP_W-1]}}, exp_in};
    assign biased = exp_sx + BW'(SP_BIAS);
    assign tiny   = (biased <= 0);

    // one shifter serves both paths; subnormals go one place further per
    // unit below biased exponent 1, saturating so all bits land in rest
    always_comb begin
        sh_req = tiny ? (NORM_SH + 1 - int'(biased)) : NORM_SH;
        if (sh_req > EXT_W - 1) sh_req = EXT_W - 1;
        shamt = SH_W'(sh_req);
    end

    assign ext_w   = {mant_in, {MANT_W{1'b0}}};
    assign shifted = ext_w >> shamt;

    always_comb begin
        al.kept  = KEEP_W'(shifted >> MANT_W);
        al.guard = shifted[MANT_W-1];
        al.rest  = (|shifted[MANT_W-2:0]) | sticky_in;
    end
endmodule

// File: rtl/fp32pk_round.sv
`timescale 1ns/1ps
module fp32pk_round
    import fp32pk_pkg::*;
(
    input  align_t            al,
    input  rnd_mode_e         mode,
    input  logic              sign,
    output logic [KEEP_W:0]   rounded,
    output logic              inexact
);
    logic inc;

    assign inc     = round_up(mode, sign, al.kept[0], al.guard, al.rest);
    assign rounded = {1'b0, al.kept} + (KEEP_W+1)'(inc);
    assign inexact = al.guard | al.rest;
endmodule

// File: rtl/fp32pk_assemble.sv
`timescale 1ns/1ps
module fp32pk_assemble
    import fp32pk_pkg::*;
#(
    parameter int BW = 12
) (
    input  fp_class_e              cls,
    input  logic                   sign,
    input  logic [SP_FRAC_W-1:0]   nan_frac,
    input  logic signed [BW-1:0]   biased,
    input  logic                   tiny,
    input  logic [KEEP_W:0]        rounded,
    input  logic                   inexact,
    input  rnd_mode_e              mode,
    output sp_word_t               word,
    output sp_flags_t              flags
);
    logic signed [BW-1:0] exp_fin;

    assign exp_fin = biased + BW'(rounded[KEEP_W]);

    always_comb begin
        word      = '0;
        flags     = '0;
        word.sign = sign;
        unique case (cls)
            CLS_ZERO: ;
            CLS_INF: word.expo = '1;
            CLS_NAN: begin
                word.expo = '1;
                word.frac = nan_frac;
            end
            default: begin
                flags.inexact = inexact;
                if (tiny) begin
                    flags.underflow = 1'b1;
                    if (rounded[KEEP_W-1]) begin
                        word.expo = SP_EXP_W'(1);
                    end else begin
                        word.frac = rounded[SP_FRAC_W-1:0];
                    end
                end else if (exp_fin >= SP_EXP_TOP) begin
                    flags.overflow = 1'b1;
                    flags.inexact  = 1'b1;
                    flags.invalid  = 1'b1;
                    if (overflow_to_inf(mode, sign)) begin
                        word.expo = '1;
                    end else begin
                        word.expo = SP_EXP_W'(SP_EXP_TOP - 1);
                        word.frac = '1;
                    end
                end else begin
                    word.expo = exp_fin[SP_EXP_W-1:0];
                    word.frac = rounded[KEEP_W] ? '0 : rounded[SP_FRAC_W-1:0];
                end
            end
        endcase
    end
endmodule

// File: rtl/fp32_result_packer.sv
`timescale 1ns/1ps
module fp32_result_packer
    import fp32pk_pkg::*;
#(
    parameter int EXP_W  = 10,
    parameter int MANT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [1:0]        in_class,
    input  logic              in_sign,
    input  logic [EXP_W-1:0]  in_exp,
    input  logic [MANT_W-1:0] in_mant,
    input  logic              in_sticky,
    input  logic [1:0]        in_rmode,
    output logic              out_valid,
    output logic [31:0]       out_word,
    output logic              out_inexact,
    output logic              out_underflow,
    output logic              out_overflow,
    output logic              out_invalid
);
    localparam int BW = EXP_W + 2;

    fp_class_e            cls;
    rnd_mode_e            mode;
    align_t               al;
    logic                 tiny;
    logic signed [BW-1:0] biased;
    logic [KEEP_W:0]      rounded;
    logic                 inexact;
    sp_word_t             word_d, word_q;
    sp_flags_t            flags_d, flags_q;
    logic                 valid_q;

    assign cls  = fp_class_e'(in_class);
    assign mode = rnd_mode_e'(in_rmode);

    fp32pk_align #(.EXP_W(EXP_W), .MANT_W(MANT_W)) u_align (
        .exp_in    (in_exp),
        .mant_in   (in_mant),
        .sticky_in (in_sticky),
        .al        (al),
        .tiny      (tiny),
        .biased    (biased)
    );

    fp32pk_round u_round (
        .al      (al),
        .mode    (mode),
        .sign    (in_sign),
        .rounded (rounded),
        .inexact (inexact)
    );

    fp32pk_assemble #(.BW(BW)) u_assemble (
        .cls      (cls),
        .sign     (in_sign),
        .nan_frac (in_mant[MANT_W-2 -: SP_FRAC_W]),
        .biased   (biased),
        .tiny     (tiny),
        .rounded  (rounded),
        .inexact  (inexact),
        .mode     (mode),
        .word     (word_d),
        .flags    (flags_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            word_q  <= '0;
            flags_q <= '0;
        end else begin
            valid_q <= in_valid;
            if (in_valid) begin
                word_q  <= word_d;
                flags_q <= flags_d;
            end
        end
    end

    assign out_valid     = valid_q;
    assign out_word      = word_q;
    assign out_inexact   = flags_q.inexact;
    assign out_underflow = flags_q.underflow;
    assign out_overflow  = flags_q.overflow;
    assign out_invalid   = flags_q.invalid;

    // R1
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!out_valid && out_word == 32'd0 && !out_inexact &&
                 !out_underflow && !out_overflow && !out_invalid));

    // R2
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(out_word) && $stable(out_overflow)));

    // R3
    a_r3_zero_sign_only: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_class == 2'd0) |=>
            (out_word[30:0] == 31'd0 && !out_inexact && !out_overflow && !out_underflow));

    // R5
    a_r5_nan_payload: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_class == 2'd3) |=>
            (out_word[30:23] == 8'hFF && out_word[22:0] == $past(in_mant[MANT_W-2 -: 23])));

    // R8
    a_r8_tiny_low_exp: assert property (@(posedge clk) disable iff (rst)
        out_underflow |-> (out_word[30:24] == 7'd0 && !out_overflow));

    // R10
    a_r10_ovf_flag_set: assert property (@(posedge clk) disable iff (rst)
        out_overflow |-> (out_inexact && out_invalid));

    // R11
    a_r11_ovf_value: assert property (@(posedge clk) disable iff (rst)
        out_overflow |-> ((out_word[30:23] == 8'hFF && out_word[22:0] == 23'd0) ||
                          (out_word[30:23] == 8'hFE && &out_word[22:0])));
endmodule

// File: tb/test_fp32_result_packer.sv
`timescale 1ns/1ps
module test_fp32_result_packer;
    localparam int EXP_W  = 10;
    localparam int MANT_W = 32;

    logic              clk = 1'b0;
    logic              rst;
    logic              in_valid;
    logic [1:0]        in_class;
    logic              in_sign;
    logic [EXP_W-1:0]  in_exp;
    logic [MANT_W-1:0] in_mant;
    logic              in_sticky;
    logic [1:0]        in_rmode;
    logic              out_valid;
    logic [31:0]       out_word;
    logic              out_inexact, out_underflow, out_overflow, out_invalid;

    int compared   = 0;
    int mismatched = 0;
    bit finished   = 0;

    logic        pend_v;
    logic [31:0] pend_w;
    logic [3:0]  pend_f;
    string       pend_tag;

    always #2.5 clk = ~clk;

    fp32_result_packer #(.EXP_W(EXP_W), .MANT_W(MANT_W)) i_fp32_result_packer (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_class(in_class),
        .in_sign(in_sign), .in_exp(in_exp), .in_mant(in_mant),
        .in_sticky(in_sticky), .in_rmode(in_rmode), .out_valid(out_valid),
        .out_word(out_word), .out_inexact(out_inexact),
        .out_underflow(out_underflow), .out_overflow(out_overflow),
        .out_invalid(out_invalid)
    );

    // behavioural reference: integer quotient/remainder rounding
    function automatic void model(input int cls, input bit sgn, input int e,
                                  input longint unsigned m, input bit stk, input int md,
                                  output logic [31:0] w, output logic [3:0] f);
        int b, s;
        bit sub, up, lossy, toinf;
        longint unsigned q, rem, half;
        w = 32'd0;
        f = 4'd0;
        case (cls)
            0: w = {sgn, 31'd0};
            2: w = {sgn, 8'hFF, 23'd0};
            3: w = {sgn, 8'hFF, m[30:8]};
            default: begin
                b = e + 127;
                sub = (b <= 0);
                s = sub ? (9 - b) : 8;
                if (s > 62) s = 62;
                q = m >> s;
                rem = m - (q << s);
                half = 64'd1 << (s - 1);
                lossy = (rem != 0) || stk;
                case (md)
                    0: up = (rem > half) || (rem == half && (stk || q[0]));
                    1: up = 0;
                    2: up = sgn && lossy;
                    default: up = !sgn && lossy;
                endcase
                q = q + longint'(up);
                f[3] = lossy;
                if (sub) begin
                    f[2] = 1;
                    if (q == (64'd1 << 23)) w = {sgn, 8'd1, 23'd0};
                    else w = {sgn, 8'd0, q[22:0]};
                end else begin
                    if (q == (64'd1 << 24)) begin
                        b = b + 1;
                        q = 64'd1 << 23;
                    end
                    if (b >= 255) begin
                        f = 4'b1011;
                        toinf = (md == 0) || (md == 3 && !sgn) || (md == 2 && sgn);
                        w = toinf ? {sgn, 8'hFF, 23'd0} : {sgn, 8'hFE, 23'h7FFFFF};
                    end else begin
                        w = {sgn, b[7:0], q[22:0]};
                    end
                end
            end
        endcase
    endfunction

    task automatic compare_now();
        logic [3:0] f_act;
        f_act = {out_inexact, out_underflow, out_overflow, out_invalid};
        compared++;
        if (out_valid !== pend_v || out_word !== pend_w || f_act !== pend_f) begin
            mismatched++;
            $display("FAIL %s: valid=%b word=%h flags=%b expected valid=%b word=%h flags=%b",
                     pend_tag, out_valid, out_word, f_act, pend_v, pend_w, pend_f);
        end
    endtask

    task automatic step(input bit v, input int cls, input bit sgn, input int e,
                        input logic [31:0] m, input bit stk, input int md, input string tag);
        logic [31:0] w;
        logic [3:0]  f;
        @(negedge clk);
        compare_now();
        in_valid  = v;
        in_class  = 2'(cls);
        in_sign   = sgn;
        in_exp    = EXP_W'(e);
        in_mant   = m;
        in_sticky = stk;
        in_rmode  = 2'(md);
        pend_v    = v;
        pend_tag  = tag;
        if (v) begin
            model(cls, sgn, e, longint'(m), stk, md, w, f);
            pend_w = w;
            pend_f = f;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            mismatched++;
            $display("FAIL watchdog: run did not complete");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        logic [31:0] lcg;
        rst = 1'b1;
        in_valid = 1'b1; in_class = 2'd1; in_sign = 1'b1; in_exp = '0;
        in_mant = 32'hFFFFFFFF; in_sticky = 1'b1; in_rmode = 2'd3;
        pend_v = 0; pend_w = 0; pend_f = 0; pend_tag = "R1";
        repeat (3) @(negedge clk);
        compare_now();                       // R1: outputs cleared under reset
        rst = 1'b0;
        in_valid = 1'b0;
        pend_v = 0; pend_tag = "R2";

        step(1, 0, 1, 0, 32'h0, 0, 0, "R3 negative zero");
        step(1, 0, 0, 5, 32'h80000000, 1, 3, "R3 positive zero");
        step(1, 2, 0, 0, 32'h0, 0, 0, "R4 +inf");
        step(1, 2, 1, 0, 32'h0, 0, 1, "R4 -inf");
        step(1, 3, 0, 0, 32'hE1234500, 0, 0, "R5 NaN payload");
        step(1, 3, 1, 0, 32'hC00000FF, 1, 2, "R5 NaN low bits dropped");
        step(0, 1, 0, 3, 32'h80000000, 0, 0, "R2 idle hold");
        step(0, 1, 0, 3, 32'h80000000, 0, 0, "R2 idle hold");
        step(1, 1, 0, 0, 32'h80000000, 0, 0, "R6 exact one");
        for (int md = 0; md < 4; md++) begin
            step(1, 1, 0, 0, 32'h80000140, 0, md, "R6 below half pos");
            step(1, 1, 1, 0, 32'h80000140, 0, md, "R6 below half neg");
            step(1, 1, 0, 0, 32'h80000080, 0, md, "R6 tie even");
            step(1, 1, 0, 0, 32'h80000180, 0, md, "R6 tie odd");
            step(1, 1, 1, 3, 32'h80000000, 1, md, "R6 sticky only");
            step(1, 1, 0, -1, 32'hFFFFFF80, 0, md, "R7 one minus half ulp");
            step(1, 1, 1, -1, 32'hFFFFFF80, 0, md, "R7 one minus half ulp neg");
            step(1, 1, 0, -127, 32'hFFFFFFFF, 0, md, "R9 largest subnormal up");
            step(1, 1, 1, -127, 32'hFFFFFE00, 0, md, "R9 largest subnormal exact");
            step(1, 1, 0, -130, 32'h80000000, 0, md, "R8 exact subnormal");
            step(1, 1, 0, -140, 32'hC0000001, 0, md, "R8 inexact subnormal");
            step(1, 1, 1, -200, 32'h80000000, 0, md, "R8 far below range");
            step(1, 1, 0, -512, 32'hFFFFFFFF, 1, md, "R8 exponent floor");
            step(1, 1, 0, 128, 32'h80000000, 0, md, "R10 R11 overflow pos");
            step(1, 1, 1, 128, 32'h80000000, 0, md, "R10 R11 overflow neg");
            step(1, 1, 0, 127, 32'hFFFFFFFF, 0, md, "R7 R10 overflow by rounding");
            step(1, 1, 1, 511, 32'hA5A5A5A5, 0, md, "R10 R11 exponent ceiling");
            step(1, 1, 0, 127, 32'hFFFFFF00, 0, md, "R6 largest finite");
            step(1, 1, 0, -126, 32'h80000000, 0, md, "R6 smallest normal");
        end
        lcg = 32'h1234ABCD;
        for (int i = 0; i < 2000; i++) begin
            logic [31:0] a, m;
            int e;
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            a = lcg;
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            m = lcg | 32'h80000000;
            e = int'(a[24:16] % 9'd320) - 170;
            step(a[7:5] != 0, (a[3:2] == 0) ? int'(a[1:0]) : 1, a[4], e, m,
                 a[8], int'(a[10:9]), "R6 R8 R10 random");
        end
        step(0, 0, 0, 0, 32'h0, 0, 0, "R2 drain");
        @(negedge clk);
        compare_now();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule